// File: doc/BRIEF.md
# Offset-Coded Programmable Clock Divider

This block divides an input clock by an integer ratio N and emits a waveform with one period per N input cycles. It sits in the reference or feedback path of a frequency synthesizer. The ratio is not written directly. A static configuration word holds N minus a fixed offset, so an all-zero word selects the smallest useful ratio. The phase comparator, charge pump, loop filter and oscillator are outside this block.

A parameter chooses one of two flavours. The feedback flavour takes a 9-bit word with an offset of 8, which covers ratios 8 to 519. Ratio 11 is not allowed in this flavour. It is flagged, and the divider runs at 12 while the flag is set. The reference flavour takes a 7-bit word with an offset of 2, which covers ratios 2 to 129, and has no forbidden value. An active-low power-down input holds the output low. When power-down is released, the divider restarts with a full period. A new word takes effect only at the end of the period in progress.

Top module: `pll_div_counter`

## Requirements
- R1: With MODE = DIV_FB, the output period is cfg_word + 8 input cycles. Word 9'b000001001 gives 17 and word 0 gives 8.
- R2: With MODE = DIV_REF, the output period is cfg_word + 2 input cycles. Word 7'b0001101 gives 15 and word 0 gives 2.
- R3: An all-ones word, which is what undriven inputs with pull-ups present, selects the largest ratio: 519 in DIV_FB mode and 129 in DIV_REF mode.
- R4: cfg_bad is 1 combinationally exactly when MODE = DIV_FB and cfg_word = 3 (ratio 11). In DIV_REF mode cfg_bad is always 0, so word 9 there is a legal ratio of 11.
- R5: While cfg_bad is 1, the divider runs with a period of 12 cycles.
- R6: Each output period begins with a rise of div_out. div_out stays high for floor(N/2) cycles and low for the remaining N - floor(N/2) cycles.
- R7: A change of cfg_word during a period does not alter that period. The new ratio applies from the next period start.
- R8: After any rising clock edge at which pwr_n is 0, div_out is 0.
- R9: At the first rising edge with pwr_n = 1 after power-down or reset, div_out rises and starts a complete period.
- R10: A synchronous active-high rst drives div_out to 0 at the next rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock to be divided |
| rst | input | 1 | Synchronous reset, active high |
| pwr_n | input | 1 | Power-down, active low; holds the output low |
| cfg_word | input | 9 (DIV_FB) or 7 (DIV_REF) | Ratio minus the mode's offset |
| div_out | output | 1 | Divided clock, registered |
| cfg_bad | output | 1 | Forbidden ratio selected (combinational) |

## Verification
The bench builds two copies of the block side by side: one with MODE = DIV_FB and one with MODE = DIV_REF. Both copies share reset and power-down. The feedback copy exercises the forbidden ratio, the substitution to 12 and the 519-cycle upper end. The reference copy exercises the very short ratios 2 and 3, where the high phase is one cycle, and shows that a ratio of 11 is legal there. Word changes land at random points within periods, so the rule that a change waits for the next period start is tested in both offset codings.

// File: rtl/pll_div_pkg.sv
package pll_div_pkg;
  typedef enum logic {DIV_REF = 1'b0, DIV_FB = 1'b1} div_mode_e;

  localparam int BAD_RATIO   = 11;
  localparam int SUBST_RATIO = 12;

  function automatic int cfg_width(input div_mode_e m);
    return (m == DIV_FB) ? 9 : 7;
  endfunction

  function automatic int ratio_offset(input div_mode_e m);
    return (m == DIV_FB) ? 8 : 2;
  endfunction
endpackage

// File: rtl/pll_div_decode.sv
module pll_div_decode
  import pll_div_pkg::*;
#(
  parameter div_mode_e MODE = DIV_FB,
  localparam int CFG_W = cfg_width(MODE),
  localparam int RW    = CFG_W + 1
) (
  input  logic [CFG_W-1:0] cfg_word,
  output logic [RW-1:0]    ratio_eff,
  output logic             bad
);
  localparam int OFFSET = ratio_offset(MODE);

  logic [RW-1:0] ratio_raw;
  assign ratio_raw = RW'(cfg_word) + RW'(OFFSET);

  // Only the feedback coding has a forbidden ratio
  generate
    if (MODE == DIV_FB) begin : g_fb_check
      assign bad = (ratio_raw == RW'(BAD_RATIO));
    end else begin : g_ref_check
      assign bad = 1'b0;
    end
  endgenerate

  assign ratio_eff = bad ? RW'(SUBST_RATIO) : ratio_raw;
endmodule

// File: rtl/pll_div_core.sv
module pll_div_core #(
  parameter int RW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pwr_n,
  input  logic [RW-1:0] ratio_in,
  output logic          div_out
);
  logic [RW-1:0] cnt;
  logic [RW-1:0] n_cur;
  logic [RW-1:0] half;
  logic [RW-1:0] cnt_nx;
  logic          idle;
  logic          wrap;

  assign half   = n_cur >> 1;
  assign cnt_nx = cnt + RW'(1);
  assign wrap   = idle || (cnt == n_cur - RW'(1));

  always_ff @(posedge clk) begin
    if (rst || !pwr_n) begin
      idle    <= 1'b1;
      cnt     <= '0;
      n_cur   <= ratio_in;
      div_out <= 1'b0;
    end else if (wrap) begin
      idle    <= 1'b0;
      cnt     <= '0;
      n_cur   <= ratio_in;
      div_out <= 1'b1;
    end else begin
      cnt     <= cnt_nx;
      div_out <= (cnt_nx < half);
    end
  end

  // R6: the phase counter never reaches the latched ratio
  a_r6_cnt_in_range: assert property (@(posedge clk) disable iff (rst)
    cnt < n_cur);

  // R7: the ratio stays the same within a period
  a_r7_ratio_hold: assert property (@(posedge clk) disable iff (rst || !pwr_n)
    !wrap |=> $stable(n_cur));

  // R8: power-down holds the output low
  a_r8_pd_low: assert property (@(posedge clk) disable iff (rst)
    !pwr_n |=> !div_out);

  // R9: leaving idle starts a fresh period high
  a_r9_restart_full: assert property (@(posedge clk) disable iff (rst)
    (idle && pwr_n) |=> (div_out && cnt == '0));

  // R10: reset clears the output
  a_r10_reset_low: assert property (@(posedge clk)
    rst |=> !div_out);
endmodule

// File: rtl/pll_div_counter.sv
module pll_div_counter
  import pll_div_pkg::*;
#(
  parameter div_mode_e MODE = DIV_FB,
  localparam int CFG_W = cfg_width(MODE),
  localparam int RW    = CFG_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pwr_n,
  input  logic [CFG_W-1:0] cfg_word,
  output logic             div_out,
  output logic             cfg_bad
);
  logic [RW-1:0] eff_ratio;

  pll_div_decode #(.MODE(MODE)) u_decode (
    .cfg_word (cfg_word),
    .ratio_eff(eff_ratio),
    .bad      (cfg_bad)
  );

  pll_div_core #(.RW(RW)) u_core (
    .clk     (clk),
    .rst     (rst),
    .pwr_n   (pwr_n),
    .ratio_in(eff_ratio),
    .div_out (div_out)
  );

  // R5: the counter is handed the substitute ratio while the flag is up
  always_comb begin
    if (cfg_bad) begin
      a_r5_subst_ratio: assert (eff_ratio == RW'(SUBST_RATIO));
    end
  end
endmodule

// File: tb/pll_div_counter_bench.sv
module pll_div_counter_bench;
  import pll_div_pkg::*;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       pwr_n = 1'b1;
  logic [8:0] w_fb = '0;
  logic [6:0] w_rf = '0;
  logic       fb_out, fb_bad, rf_out, rf_bad;

  int checks = 0;
  int errors = 0;
  bit model_on = 1'b0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pll_div_counter #(.MODE(DIV_FB)) u_pll_div_counter (
    .clk(clk), .rst(rst), .pwr_n(pwr_n), .cfg_word(w_fb),
    .div_out(fb_out), .cfg_bad(fb_bad));

  pll_div_counter #(.MODE(DIV_REF)) u_pll_div_counter_ref (
    .clk(clk), .rst(rst), .pwr_n(pwr_n), .cfg_word(w_rf),
    .div_out(rf_out), .cfg_bad(rf_bad));

  function automatic int exp_ratio(input int word, input bit fb);
    int r;
    r = fb ? word + 8 : word + 2;
    if (fb && r == 11) r = 12;
    return r;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic bit get_out(input bit use_ref);
    return use_ref ? rf_out : fb_out;
  endfunction

  // Called at the first negedge on which a new period shows high
  task automatic from_rise(input bit use_ref, output int hi, output int per);
    bit prev, cur;
    hi = 1; per = 1; prev = 1'b1;
    for (int k = 0; k < 2000; k++) begin
      @(negedge clk);
      cur = get_out(use_ref);
      if (cur && !prev) break;
      per++;
      if (cur) hi++;
      prev = cur;
    end
  endtask

  task automatic wait_rise(input bit use_ref);
    bit prev, cur;
    prev = get_out(use_ref);
    for (int k = 0; k < 2000; k++) begin
      @(negedge clk);
      cur = get_out(use_ref);
      if (cur && !prev) break;
      prev = cur;
    end
  endtask

  task automatic measure(input bit use_ref, output int hi, output int per);
    wait_rise(use_ref);
    from_rise(use_ref, hi, per);
  endtask

  // Reference model, advanced at every rising edge
  int  mf_pos = 0, mf_n = 8, mr_pos = 0, mr_n = 2;
  bit  mf_idle = 1, mr_idle = 1, mf_out = 0, mr_out = 0;

  always @(posedge clk) begin
    if (rst || !pwr_n) begin
      mf_idle = 1; mf_out = 0; mf_pos = 0;
      mr_idle = 1; mr_out = 0; mr_pos = 0;
    end else begin
      if (mf_idle || mf_pos == mf_n - 1) begin
        mf_pos = 0; mf_n = exp_ratio(int'(w_fb), 1'b1); mf_out = 1; mf_idle = 0;
      end else begin
        mf_pos++; mf_out = (mf_pos < mf_n / 2);
      end
      if (mr_idle || mr_pos == mr_n - 1) begin
        mr_pos = 0; mr_n = exp_ratio(int'(w_rf), 1'b0); mr_out = 1; mr_idle = 0;
      end else begin
        mr_pos++; mr_out = (mr_pos < mr_n / 2);
      end
    end
  end

  always @(negedge clk) begin
    if (model_on) begin
      chk("R6 R7 feedback model", int'(fb_out), int'(mf_out));
      chk("R6 R7 reference model", int'(rf_out), int'(mr_out));
      chk("R4 feedback flag", int'(fb_bad), int'(w_fb == 9'd3));
      chk("R4 reference flag", int'(rf_bad), 0);
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual 0 expected 1");
    finish_run();
  end

  initial begin
    int hi, per, hold;
    void'($urandom(32'h5eed_2024));

    // R10 reset state
    repeat (3) @(negedge clk);
    chk("R10 feedback out in reset", int'(fb_out), 0);
    chk("R10 reference out in reset", int'(rf_out), 0);

    // R1 R2 R6 worked examples
    w_fb = 9'b000001001; w_rf = 7'b0001101;
    rst = 1'b0;
    measure(1'b0, hi, per);
    chk("R1 period word 9", per, 17);
    chk("R6 high for ratio 17", hi, 8);
    measure(1'b1, hi, per);
    chk("R2 period word 13", per, 15);
    chk("R6 high for ratio 15", hi, 7);

    // R1 R2 smallest ratios
    w_fb = 9'd0; w_rf = 7'd0;
    measure(1'b0, hi, per);
    measure(1'b0, hi, per);
    chk("R1 period word 0", per, 8);
    chk("R6 high for ratio 8", hi, 4);
    measure(1'b1, hi, per);
    measure(1'b1, hi, per);
    chk("R2 period word 0", per, 2);
    chk("R6 high for ratio 2", hi, 1);
    w_rf = 7'd1;
    measure(1'b1, hi, per);
    measure(1'b1, hi, per);
    chk("R6 ratio 3 period", per, 3);
    chk("R6 ratio 3 high", hi, 1);

    // R3 all ones
    w_fb = '1; w_rf = '1;
    measure(1'b0, hi, per);
    measure(1'b0, hi, per);
    chk("R3 feedback max period", per, 519);
    chk("R3 feedback max high", hi, 259);
    measure(1'b1, hi, per);
    measure(1'b1, hi, per);
    chk("R3 reference max period", per, 129);
    chk("R3 reference max high", hi, 64);

    // R4 R5 forbidden ratio
    w_fb = 9'd3; w_rf = 7'd9;
    #1;
    chk("R4 flag for ratio 11", int'(fb_bad), 1);
    chk("R4 no flag in reference", int'(rf_bad), 0);
    measure(1'b0, hi, per);
    measure(1'b0, hi, per);
    chk("R5 substituted period", per, 12);
    chk("R5 substituted high", hi, 6);
    measure(1'b1, hi, per);
    measure(1'b1, hi, per);
    chk("R4 reference ratio 11 legal", per, 11);
    w_fb = 9'd4;
    #1;
    chk("R4 flag clears for ratio 12", int'(fb_bad), 0);

    // R7 mid-period change
    w_fb = 9'd9;
    measure(1'b0, hi, per);
    measure(1'b0, hi, per);
    wait_rise(1'b0);
    repeat (3) @(negedge clk);
    w_fb = 9'd0;
    begin
      int extra;
      extra = 0;
      for (int k = 0; k < 100; k++) begin
        @(negedge clk);
        extra++;
        if (fb_out && extra > 9) break;
      end
      chk("R7 running period kept", 4 + extra - 1, 17);
    end
    from_rise(1'b0, hi, per);
    chk("R7 new ratio next period", per, 8);

    // R8 power-down, R9 restart
    w_fb = 9'd9; w_rf = 7'd13;
    pwr_n = 1'b0;
    @(negedge clk);
    chk("R8 feedback low", int'(fb_out), 0);
    chk("R8 reference low", int'(rf_out), 0);
    begin
      int seen;
      seen = 0;
      for (int k = 0; k < 30; k++) begin
        @(negedge clk);
        if (fb_out || rf_out) seen++;
      end
      chk("R8 held low", seen, 0);
    end
    pwr_n = 1'b1;
    @(negedge clk);
    chk("R9 rise on release", int'(fb_out), 1);
    chk("R9 reference rise on release", int'(rf_out), 1);
    from_rise(1'b0, hi, per);
    chk("R9 first period full", per, 17);
    chk("R9 first high full", hi, 8);

    // Random phase against the model
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    model_on = 1'b1;
    for (int i = 0; i < 40; i++) begin
      case ($urandom % 8)
        0: w_fb = 9'd3;
        1: w_fb = 9'd0;
        2: w_fb = '1;
        default: w_fb = 9'($urandom);
      endcase
      w_rf = 7'($urandom);
      hold = 20 + int'($urandom % 700);
      repeat (hold) @(negedge clk);
      if (i % 7 == 3) begin
        pwr_n = 1'b0;
        repeat (1 + $urandom % 6) @(negedge clk);
        pwr_n = 1'b1;
      end
    end
    model_on = 1'b0;
    finish_run();
  end
endmodule